// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block turns a 16-bit processor address into one of three selects (RAM, ROM, device space) and, for RAM accesses, a 17-bit physical address into a 128K RAM. The lowest 16K of the processor space is a window. A 3-bit bank register picks which of the eight 16K physical banks shows through that window. Above the window sits 24K of RAM that never moves, then a 4K device window, then a 20K top region.

The top region behaves one of two ways, chosen by a static mode input. In ROM mode it selects the ROM and can never be written. In RAM-only mode it becomes ordinary writable RAM at the physical address equal to the processor address. The bank register sits at one fixed address inside the device window. A strobed processor write to that address loads the register from the low data bits on the next clock edge. Because bank 2 covers physical 0x08000–0x0BFFF, its lower half reaches the same cells as the top of the fixed region.

Top module: `mem_map_decoder`

## Requirements
- R1: For addresses 0x0000–0x3FFF, ram_sel is 1 and ram_addr equals bank×0x4000 plus the address, where bank is the current bank register value.
- R2: For addresses 0x4000–0x9FFF, ram_sel is 1 and ram_addr equals the address (physical 0x04000–0x09FFF) whatever the bank register holds.
- R3: For addresses 0xA000–0xAFFF, io_sel is 1 and both ram_sel and rom_sel are 0.
- R4: With ram_only = 0, addresses 0xB000–0xFFFF give rom_sel = 1, ram_sel = 0 and ram_we = 0, even when cpu_rd_n = 0 (a write).
- R5: With ram_only = 1, addresses 0xB000–0xFFFF give ram_sel = 1, rom_sel = 0 and ram_addr equal to the address (0x0B000–0x0FFFF), and writes assert ram_we.
- R6: Exactly one of ram_sel, rom_sel and io_sel is 1 for every address.
- R7: ram_we is 1 exactly when ram_sel is 1 and cpu_rd_n is 0 (cpu_rd_n = 1 means read, 0 means write).
- R8: When bank_wr_stb = 1, cpu_rd_n = 0 and cpu_addr = 0xAFF0 at a rising clock edge, the bank register takes cpu_data_lo[2:0] at that edge. The new bank applies to window accesses from the next cycle on.
- R9: After reset the bank register holds 0, so 0x0000–0x9FFF is 40K of contiguous RAM at physical 0x00000–0x09FFF.
- R10: With bank 2 selected, window offsets 0x0000–0x1FFF map to physical 0x08000–0x09FFF, the same cells as addresses 0x8000–0x9FFF.
- R11: A strobe during a read, or a strobe with any address other than 0xAFF0, leaves the bank register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bank register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_rd_n | input | 1 | 1 = read, 0 = write |
| bank_wr_stb | input | 1 | Qualifies a bank register write |
| cpu_data_lo | input | 3 | Low data bits loaded into the bank register |
| ram_only | input | 1 | 1 = top region is RAM, 0 = top region is ROM |
| ram_sel | output | 1 | RAM chip select |
| rom_sel | output | 1 | ROM chip select |
| io_sel | output | 1 | Device window select |
| ram_addr | output | 17 | Physical RAM address |
| ram_we | output | 1 | RAM write enable |

## Verification
The bench targets the region boundaries (0x3FFF/0x4000, 0x9FFF/0xA000, 0xAFFF/0xB000). A comparator off by one there would hand an address to the wrong chip. It checks the highest bank at the highest offset, which catches a truncated bank field that would fold bank 7 onto bank 3. It checks the bank 2 alias against the fixed region, and it checks that a ROM-mode write leaves ram_we low, since a leaky enable would corrupt the RAM cells underneath. Strobes during reads, strobes with neighbouring addresses, and a reset after a bank change must all leave the window on the expected bank. A decoder that loosely matched the register address would move the window when it should not.

// File: rtl/mem_map_pkg.sv
package mem_map_pkg;

    typedef enum logic [1:0] {
        RGN_WINDOW = 2'd0,
        RGN_FIXED  = 2'd1,
        RGN_DEVICE = 2'd2,
        RGN_TOP    = 2'd3
    } region_e;

endpackage

// File: rtl/bank_reg.sv
module bank_reg #(
    parameter int          ADDR_W   = 16,
    parameter int          BANK_W   = 3,
    parameter logic [15:0] REG_ADDR = 16'hAFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd_n,
    input  logic              bank_wr_stb,
    input  logic [BANK_W-1:0] cpu_data_lo,
    output logic [BANK_W-1:0] bank_q
);

    typedef struct packed {
        logic [BANK_W-1:0] bank;
    } state_t;

    state_t state_d;
    state_t state_q;
    logic   hit;

    always_comb begin
        hit     = bank_wr_stb && !cpu_rd_n && (cpu_addr == ADDR_W'(REG_ADDR));
        state_d = state_q;
        if (hit) begin
            state_d.bank = cpu_data_lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bank_q = state_q.bank;

    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_wr_stb && !cpu_rd_n && cpu_addr == ADDR_W'(REG_ADDR))
        |=> bank_q == $past(cpu_data_lo)); // R8

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bank_wr_stb && !cpu_rd_n && cpu_addr == ADDR_W'(REG_ADDR))
        |=> $stable(bank_q)); // R11

endmodule

// File: rtl/region_classify.sv
module region_classify
    import mem_map_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] FIXED_BASE = 16'h4000,
    parameter logic [15:0] DEV_BASE   = 16'hA000,
    parameter logic [15:0] TOP_BASE   = 16'hB000
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    output region_e           region
);

    always_comb begin
        if (cpu_addr < ADDR_W'(FIXED_BASE)) begin
            region = RGN_WINDOW;
        end else if (cpu_addr < ADDR_W'(DEV_BASE)) begin
            region = RGN_FIXED;
        end else if (cpu_addr < ADDR_W'(TOP_BASE)) begin
            region = RGN_DEVICE;
        end else begin
            region = RGN_TOP;
        end
    end

endmodule

// File: rtl/phys_map.sv
module phys_map
    import mem_map_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 3,
    parameter int WIN_W  = 14,
    localparam int PHYS_W = BANK_W + WIN_W
) (
    input  region_e           region,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BANK_W-1:0] bank,
    output logic [PHYS_W-1:0] ram_addr
);

    always_comb begin
        if (region == RGN_WINDOW) begin
            ram_addr = {bank, cpu_addr[WIN_W-1:0]};
        end else begin
            ram_addr = PHYS_W'(cpu_addr);
        end
    end

endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
    import mem_map_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          BANK_W     = 3,
    parameter logic [15:0] FIXED_BASE = 16'h4000,
    parameter logic [15:0] DEV_BASE   = 16'hA000,
    parameter logic [15:0] TOP_BASE   = 16'hB000,
    parameter logic [15:0] REG_ADDR   = 16'hAFF0,
    localparam int WIN_W  = ADDR_W - 2,
    localparam int PHYS_W = BANK_W + WIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd_n,
    input  logic              bank_wr_stb,
    input  logic [BANK_W-1:0] cpu_data_lo,
    input  logic              ram_only,
    output logic              ram_sel,
    output logic              rom_sel,
    output logic              io_sel,
    output logic [PHYS_W-1:0] ram_addr,
    output logic              ram_we
);

    logic [BANK_W-1:0] bank_q;
    region_e           region;

    bank_reg #(
        .ADDR_W   (ADDR_W),
        .BANK_W   (BANK_W),
        .REG_ADDR (REG_ADDR)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_addr    (cpu_addr),
        .cpu_rd_n    (cpu_rd_n),
        .bank_wr_stb (bank_wr_stb),
        .cpu_data_lo (cpu_data_lo),
        .bank_q      (bank_q)
    );

    region_classify #(
        .ADDR_W     (ADDR_W),
        .FIXED_BASE (FIXED_BASE),
        .DEV_BASE   (DEV_BASE),
        .TOP_BASE   (TOP_BASE)
    ) u_region (
        .cpu_addr (cpu_addr),
        .region   (region)
    );

    phys_map #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .WIN_W  (WIN_W)
    ) u_phys (
        .region   (region),
        .cpu_addr (cpu_addr),
        .bank     (bank_q),
        .ram_addr (ram_addr)
    );

    always_comb begin
        ram_sel = 1'b0;
        rom_sel = 1'b0;
        io_sel  = 1'b0;
        unique case (region)
            RGN_WINDOW, RGN_FIXED: ram_sel = 1'b1;
            RGN_DEVICE:            io_sel  = 1'b1;
            RGN_TOP: begin
                if (ram_only) begin
                    ram_sel = 1'b1;
                end else begin
                    rom_sel = 1'b1;
                end
            end
            default: io_sel = 1'b0;
        endcase
        ram_we = ram_sel && !cpu_rd_n;
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ram_sel, rom_sel, io_sel}) == 1); // R6

    AST_ROM_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> !ram_we); // R4

    AST_WE_NEEDS_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_sel && !cpu_rd_n)); // R7

    AST_WINDOW_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < ADDR_W'(FIXED_BASE)) |-> (ram_addr[PHYS_W-1:WIN_W] == bank_q)); // R1

    AST_FIXED_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr >= ADDR_W'(FIXED_BASE) && cpu_addr < ADDR_W'(DEV_BASE))
        |-> (ram_sel && ram_addr == PHYS_W'(cpu_addr))); // R2

    AST_DEVICE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr >= ADDR_W'(DEV_BASE) && cpu_addr < ADDR_W'(TOP_BASE))
        |-> (io_sel && !ram_sel && !rom_sel)); // R3

    AST_TOP_RAM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_only && cpu_addr >= ADDR_W'(TOP_BASE))
        |-> (ram_sel && ram_addr == PHYS_W'(cpu_addr))); // R5

endmodule

// File: tb/tb_mem_map_decoder.sv
module tb_mem_map_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_rd_n = 1'b1;
    logic        bank_wr_stb = 1'b0;
    logic [2:0]  cpu_data_lo = 3'd0;
    logic        ram_only = 1'b0;
    logic        ram_sel, rom_sel, io_sel, ram_we;
    logic [16:0] ram_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mem_map_decoder dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd_n(cpu_rd_n),
        .bank_wr_stb(bank_wr_stb), .cpu_data_lo(cpu_data_lo), .ram_only(ram_only),
        .ram_sel(ram_sel), .rom_sel(rom_sel), .io_sel(io_sel),
        .ram_addr(ram_addr), .ram_we(ram_we)
    );

    // entry: bank(3) ram_only(1) rd_n(1) addr(16) sel{ram,rom,io}(3) we(1) phys(17)
    localparam int NV = 15;
    localparam logic [41:0] VEC [NV] = '{
        {3'd0, 1'b0, 1'b1, 16'h0000, 3'b100, 1'b0, 17'h00000}, // R1 R9
        {3'd0, 1'b0, 1'b0, 16'h3FFF, 3'b100, 1'b1, 17'h03FFF}, // R1 R7
        {3'd5, 1'b0, 1'b1, 16'h1234, 3'b100, 1'b0, 17'h15234}, // R1
        {3'd7, 1'b0, 1'b0, 16'h3FFF, 3'b100, 1'b1, 17'h1FFFF}, // R1
        {3'd2, 1'b0, 1'b1, 16'h0000, 3'b100, 1'b0, 17'h08000}, // R10
        {3'd2, 1'b0, 1'b0, 16'h1FFF, 3'b100, 1'b1, 17'h09FFF}, // R10
        {3'd3, 1'b0, 1'b1, 16'h4000, 3'b100, 1'b0, 17'h04000}, // R2
        {3'd3, 1'b0, 1'b0, 16'h9FFF, 3'b100, 1'b1, 17'h09FFF}, // R2 R10
        {3'd0, 1'b0, 1'b1, 16'hA000, 3'b001, 1'b0, 17'h00000}, // R3
        {3'd0, 1'b0, 1'b0, 16'hAFFF, 3'b001, 1'b0, 17'h00000}, // R3 R7
        {3'd0, 1'b0, 1'b1, 16'hB000, 3'b010, 1'b0, 17'h00000}, // R4
        {3'd0, 1'b0, 1'b0, 16'hFFFF, 3'b010, 1'b0, 17'h00000}, // R4
        {3'd0, 1'b1, 1'b1, 16'hB000, 3'b100, 1'b0, 17'h0B000}, // R5
        {3'd0, 1'b1, 1'b0, 16'hFFFF, 3'b100, 1'b1, 17'h0FFFF}, // R5
        {3'd1, 1'b1, 1'b1, 16'h2000, 3'b100, 1'b0, 17'h06000}  // R1
    };

    task automatic check(input string req, input logic [2:0] esel,
                         input logic ewe, input logic [16:0] eaddr);
        n_cmp++;
        if ({ram_sel, rom_sel, io_sel} !== esel || ram_we !== ewe ||
            (esel[2] && ram_addr !== eaddr)) begin
            n_bad++;
            $display("FAIL %s: addr=%h sel=%b we=%b phys=%h, expected sel=%b we=%b phys=%h",
                     req, cpu_addr, {ram_sel, rom_sel, io_sel}, ram_we, ram_addr,
                     esel, ewe, eaddr);
        end
    endtask

    task automatic bank_write(input logic [15:0] a, input logic rd_n, input logic [2:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd_n = rd_n; cpu_data_lo = d; bank_wr_stb = 1'b1;
        @(negedge clk);
        bank_wr_stb = 1'b0; cpu_rd_n = 1'b1;
    endtask

    task automatic probe(input logic [15:0] a, input logic rd_n);
        @(negedge clk);
        cpu_addr = a; cpu_rd_n = rd_n;
        #5;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state, bank 0
        probe(16'h1000, 1'b1);
        check("R9", 3'b100, 1'b0, 17'h01000);

        for (int i = 0; i < NV; i++) begin
            bank_write(16'hAFF0, 1'b0, VEC[i][41:39]);
            ram_only = VEC[i][38];
            probe(VEC[i][36:21], VEC[i][37]);
            check("R1-table", VEC[i][20:18], VEC[i][17], VEC[i][16:0]);
        end
        ram_only = 1'b0;

        // R8: new bank visible only after the edge
        bank_write(16'hAFF0, 1'b0, 3'd6);
        probe(16'h0010, 1'b1);
        check("R8", 3'b100, 1'b0, 17'h18010);

        // R11: strobe during a read
        bank_write(16'hAFF0, 1'b1, 3'd1);
        probe(16'h0010, 1'b1);
        check("R11", 3'b100, 1'b0, 17'h18010);

        // R11: strobe at neighbouring addresses
        bank_write(16'hAFF1, 1'b0, 3'd1);
        bank_write(16'hAFE0, 1'b0, 3'd2);
        probe(16'h0010, 1'b1);
        check("R11", 3'b100, 1'b0, 17'h18010);

        // R10: write through alias, fixed side is the same cell
        bank_write(16'hAFF0, 1'b0, 3'd2);
        probe(16'h1ABC, 1'b0);
        check("R10", 3'b100, 1'b1, 17'h09ABC);
        probe(16'h9ABC, 1'b1);
        check("R10", 3'b100, 1'b0, 17'h09ABC);

        // R4: ROM-mode write at the boundary
        probe(16'hB000, 1'b0);
        check("R4", 3'b010, 1'b0, 17'h00000);
        // R3/R2 boundaries
        probe(16'hAFF0, 1'b0);
        check("R3", 3'b001, 1'b0, 17'h00000);
        probe(16'h3FFF, 1'b1);
        check("R1", 3'b100, 1'b0, 17'h0BFFF);

        // R9: reset after a bank change returns to bank 0
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        probe(16'h2345, 1'b1);
        check("R9", 3'b100, 1'b0, 17'h02345);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule